// File: doc/BRIEF.md
# Upward Stack Push/Pop Engine with Clear-on-Pop

This block carries out a single stack transfer per request against a byte-addressed, single-port memory with byte enables. A request holds an operation code, a data value, the current program counter and the current stack pointer. The engine writes or reads memory over two or three cycles. It then presents the new stack pointer, the fetched value and a one-cycle completion pulse. The stack grows toward higher addresses. A push writes at the pointer and then moves the pointer up by the transfer size.

A pop reads at the pointer and sign- or zero-extends the fetched bytes. In the next cycle it overwrites the same bytes with zero, so a consumed entry never lingers in memory, and then it moves the pointer down. One push code saves the program counter for a call, and one pop code returns a saved program counter for a return. Memory is little-endian. The low pointer bits select the byte lanes, and transfers are assumed to be naturally aligned. The memory answers a read with data on the cycle after the request.

Top module: `upstack_engine`

## Requirements
- R1: While reset is held and in the first idle cycle after it, busy, done, err and memEn are 0, and spOut and popData are 0.
- R2: Push codes are 0x0 (full register), 0x1 (low 8 bits), 0x2 (low 16 bits) and 0x3 (low 32 bits). A push writes the low N bytes of opData starting at address spIn, in little-endian order. It enables only those byte lanes, counting the lane from spIn modulo the register size, and leaves every other byte unchanged. It then reports spOut = spIn + N.
- R3: Code 0x4 writes the full register-width pcIn at spIn and reports spOut = spIn + register size (4 bytes by default).
- R4: Pop codes are 0x8 (full register), 0x9 and 0xA (8-bit, signed and unsigned), 0xB and 0xC (16-bit, signed and unsigned), and 0xD and 0xE (32-bit, signed and unsigned). A pop returns on popData the N bytes read at spIn. The signed forms replicate the top fetched bit into the upper bytes and the unsigned forms fill them with zero. It reports spOut = spIn - N.
- R5: Every pop issues exactly one read and then, on the next cycle, exactly one write of zero to the same address and byte lanes. After the pop those bytes read back as zero.
- R6: Code 0xF returns the full register stored at spIn on popData and reports spOut = spIn - register size.
- R7: done is a one-cycle pulse, 2 cycles after the accept edge for a push and 3 cycles after it for a pop. busy is high from the cycle after the accept through the done cycle. spOut, popData and err are valid while done is high.
- R8: Codes 0x5, 0x6 and 0x7 complete 1 cycle after the accept edge with err = 1, spOut = spIn and popData = 0, and make no memory access.
- R9: opValid is accepted only while busy is 0. A request presented while busy has no effect on memory or on the running operation's results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Request strobe, taken when idle |
| opCode | input | 4 | Operation code |
| opData | input | DATA_W | Value to push |
| pcIn | input | DATA_W | Program counter for the call-style push |
| spIn | input | ADDR_W | Stack pointer at request time |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| err | output | 1 | Undefined operation code reported |
| spOut | output | ADDR_W | Updated stack pointer |
| popData | output | DATA_W | Extended popped value or returned program counter |
| memEn | output | 1 | Memory request |
| memWe | output | 1 | Write when high, read when low |
| memAddr | output | ADDR_W | Byte address |
| memBe | output | REG_BYTES | Byte-lane enables |
| memWdata | output | DATA_W | Write data placed in its lanes |
| memRdata | input | DATA_W | Read data, one cycle after the read request |

## Verification
The bench builds the engine with its defaults: a 4-byte register and an 8-bit byte address, backed by a 256-byte memory model. With a 4-byte register, pointers at every lane offset exercise byte enables, lane shifting and sign replication at every position within a word. An 8-bit address keeps the whole stack visible to the bench's memory model. That lets it confirm zero clearing after pops and untouched neighbours after narrow pushes. Counting memory requests per operation shows the single write of a push, the read-then-clear pair of a pop and the absence of any access for an undefined code.

// File: rtl/upstack_pkg.sv
package upstack_pkg;

  typedef enum logic [1:0] {SZ_B, SZ_H, SZ_W, SZ_R} sizeSel_e;

  typedef struct packed {
    logic     legal;
    logic     isPop;
    logic     usePc;
    logic     signExt;
    sizeSel_e size;
  } opInfo_t;

  typedef struct packed {
    logic ldOp;
    logic memRd;
    logic memWr;
    logic memClr;
    logic ldSp;
    logic ldPop;
  } strobe_t;

  function automatic opInfo_t decodeOp(input logic [3:0] code);
    opInfo_t r;
    r = '{legal: 1'b1, isPop: code[3], usePc: 1'b0, signExt: 1'b0, size: SZ_R};
    case (code)
      4'h0: r.size = SZ_R;
      4'h1: r.size = SZ_B;
      4'h2: r.size = SZ_H;
      4'h3: r.size = SZ_W;
      4'h4: r.usePc = 1'b1;
      4'h8: r.size = SZ_R;
      4'h9: begin r.size = SZ_B; r.signExt = 1'b1; end
      4'hA: r.size = SZ_B;
      4'hB: begin r.size = SZ_H; r.signExt = 1'b1; end
      4'hC: r.size = SZ_H;
      4'hD: begin r.size = SZ_W; r.signExt = 1'b1; end
      4'hE: r.size = SZ_W;
      4'hF: r.size = SZ_R;
      default: r.legal = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/upstack_ctrl.sv
module upstack_ctrl
  import upstack_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    opValid,
  input  logic [3:0] opCode,
  output strobe_t stb,
  output logic    busy,
  output logic    done
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_WRITE, ST_READ, ST_CLEAR, ST_FINISH, ST_FAULT
  } state_e;

  state_e state, stateNext;
  logic   accept;

  assign accept = opValid && (state == ST_IDLE);

  always_comb begin
    stb       = '0;
    stateNext = state;
    case (state)
      ST_IDLE: if (accept) begin
        stb.ldOp = 1'b1;
        if (!decodeOp(opCode).legal)     stateNext = ST_FAULT;
        else if (decodeOp(opCode).isPop) stateNext = ST_READ;
        else                             stateNext = ST_WRITE;
      end
      ST_WRITE: begin
        stb.memWr = 1'b1;
        stb.ldSp  = 1'b1;
        stateNext = ST_FINISH;
      end
      ST_READ: begin
        stb.memRd = 1'b1;
        stateNext = ST_CLEAR;
      end
      ST_CLEAR: begin
        stb.memWr  = 1'b1;
        stb.memClr = 1'b1;
        stb.ldPop  = 1'b1;
        stb.ldSp   = 1'b1;
        stateNext  = ST_FINISH;
      end
      ST_FINISH: stateNext = ST_IDLE;
      ST_FAULT:  stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FINISH) || (state == ST_FAULT);

endmodule

// File: rtl/upstack_dpath.sv
module upstack_dpath
  import upstack_pkg::*;
#(
  parameter int REG_BYTES = 4,
  parameter int ADDR_W    = 8,
  localparam int DATA_W   = 8 * REG_BYTES,
  localparam int LANE_W   = $clog2(REG_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           stb,
  input  logic [3:0]        opCode,
  input  logic [DATA_W-1:0] opData,
  input  logic [DATA_W-1:0] pcIn,
  input  logic [ADDR_W-1:0] spIn,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] spOut,
  output logic [DATA_W-1:0] popData,
  output logic              err,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [REG_BYTES-1:0] memBe,
  output logic [DATA_W-1:0] memWdata
);

  logic [ADDR_W-1:0] spReg;
  logic [DATA_W-1:0] dataReg;
  logic              popReg, signReg;
  sizeSel_e          sizeReg;
  opInfo_t           inInfo;

  logic [LANE_W-1:0]    laneOff;
  int                   nBytes;
  logic [REG_BYTES-1:0] laneBe;
  logic [DATA_W-1:0]    shifted, popExt;
  logic                 signBit;

  assign inInfo  = decodeOp(opCode);
  assign laneOff = spReg[LANE_W-1:0];

  always_comb begin
    case (sizeReg)
      SZ_B:    nBytes = 1;
      SZ_H:    nBytes = 2;
      SZ_W:    nBytes = 4;
      default: nBytes = REG_BYTES;
    endcase
  end

  always_comb begin
    for (int i = 0; i < REG_BYTES; i++) laneBe[i] = (i < nBytes);
  end

  assign shifted = memRdata >> {laneOff, 3'b000};

  always_comb begin
    case (sizeReg)
      SZ_B:    signBit = signReg & shifted[7];
      SZ_H:    signBit = signReg & shifted[15];
      SZ_W:    signBit = signReg & shifted[31];
      default: signBit = signReg & shifted[DATA_W-1];
    endcase
    for (int i = 0; i < REG_BYTES; i++)
      popExt[8*i +: 8] = (i < nBytes) ? shifted[8*i +: 8] : {8{signBit}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spReg   <= '0;
      dataReg <= '0;
      popReg  <= 1'b0;
      signReg <= 1'b0;
      sizeReg <= SZ_R;
      spOut   <= '0;
      popData <= '0;
      err     <= 1'b0;
    end else begin
      if (stb.ldOp) begin
        spReg   <= spIn;
        dataReg <= inInfo.usePc ? pcIn : opData;
        popReg  <= inInfo.isPop;
        signReg <= inInfo.signExt;
        sizeReg <= inInfo.size;
        spOut   <= spIn;
        popData <= '0;
        err     <= !inInfo.legal;
      end
      if (stb.ldSp)
        spOut <= popReg ? spReg - ADDR_W'(nBytes) : spReg + ADDR_W'(nBytes);
      if (stb.ldPop)
        popData <= popExt;
    end
  end

  assign memEn    = stb.memRd | stb.memWr;
  assign memWe    = stb.memWr;
  assign memAddr  = spReg;
  assign memBe    = memEn ? (laneBe << laneOff) : '0;
  assign memWdata = stb.memClr ? '0 : (dataReg << {laneOff, 3'b000});

endmodule

// File: rtl/upstack_engine.sv
module upstack_engine
  import upstack_pkg::*;
#(
  parameter int REG_BYTES = 4,
  parameter int ADDR_W    = 8,
  localparam int DATA_W   = 8 * REG_BYTES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 opValid,
  input  logic [3:0]           opCode,
  input  logic [DATA_W-1:0]    opData,
  input  logic [DATA_W-1:0]    pcIn,
  input  logic [ADDR_W-1:0]    spIn,
  output logic                 busy,
  output logic                 done,
  output logic                 err,
  output logic [ADDR_W-1:0]    spOut,
  output logic [DATA_W-1:0]    popData,
  output logic                 memEn,
  output logic                 memWe,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [REG_BYTES-1:0] memBe,
  output logic [DATA_W-1:0]    memWdata,
  input  logic [DATA_W-1:0]    memRdata
);

  strobe_t stb;

  upstack_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opCode(opCode),
    .stb(stb), .busy(busy), .done(done)
  );

  upstack_dpath #(.REG_BYTES(REG_BYTES), .ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .stb(stb), .opCode(opCode),
    .opData(opData), .pcIn(pcIn), .spIn(spIn), .memRdata(memRdata),
    .spOut(spOut), .popData(popData), .err(err),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .memBe(memBe), .memWdata(memWdata)
  );

endmodule

// File: rtl/upstack_checker.sv
module upstack_checker #(
  parameter int REG_BYTES = 4,
  parameter int ADDR_W    = 8,
  localparam int DATA_W   = 8 * REG_BYTES
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 busy,
  input logic                 done,
  input logic                 err,
  input logic                 memEn,
  input logic                 memWe,
  input logic [ADDR_W-1:0]    memAddr,
  input logic [REG_BYTES-1:0] memBe,
  input logic [DATA_W-1:0]    memWdata
);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !memEn);

  assert_fault_fast_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (!$past(busy) && !memEn));

  assert_clear_follows_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (memEn && !memWe) |=> (memEn && memWe && memWdata == '0
                           && $stable(memAddr) && $stable(memBe)));

  assert_no_access_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !memEn);

endmodule

bind upstack_engine upstack_checker #(.REG_BYTES(REG_BYTES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memBe(memBe),
  .memWdata(memWdata)
);

// File: tb/sim_upstack_engine.sv
module sim_upstack_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        opValid = 1'b0;
  logic [3:0]  opCode = '0;
  logic [31:0] opData = '0, pcIn = '0;
  logic [7:0]  spIn = '0;
  logic        busy, done, err, memEn, memWe;
  logic [7:0]  spOut, memAddr;
  logic [31:0] popData, memWdata;
  logic [31:0] memRdata = '0;
  logic [3:0]  memBe;

  bit [7:0] mem [256];
  int memAcc = 0;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  upstack_engine u0 (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opCode(opCode),
    .opData(opData), .pcIn(pcIn), .spIn(spIn), .busy(busy), .done(done),
    .err(err), .spOut(spOut), .popData(popData), .memEn(memEn),
    .memWe(memWe), .memAddr(memAddr), .memBe(memBe),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  always @(posedge clk) begin
    if (memEn) begin
      memAcc = memAcc + 1;
      if (memWe) begin
        for (int i = 0; i < 4; i++)
          if (memBe[i]) mem[{memAddr[7:2], 2'(i)}] = memWdata[8*i +: 8];
      end else begin
        memRdata <= {mem[{memAddr[7:2], 2'd3}], mem[{memAddr[7:2], 2'd2}],
                     mem[{memAddr[7:2], 2'd1}], mem[{memAddr[7:2], 2'd0}]};
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {op, data, pc, sp, expSp, expPop, expErr}
  localparam int NV = 17;
  localparam logic [116:0] VEC [NV] = '{
    {4'h0, 32'h8899AABB, 32'h0,        8'h10, 8'h14, 32'h0,        1'b0},
    {4'h1, 32'h123456F0, 32'h0,        8'h14, 8'h15, 32'h0,        1'b0},
    {4'h2, 32'hABCD8001, 32'h0,        8'h16, 8'h18, 32'h0,        1'b0},
    {4'h4, 32'hDEAD0000, 32'h00C0FFEE, 8'h18, 8'h1C, 32'h0,        1'b0},
    {4'h9, 32'h0,        32'h0,        8'h14, 8'h13, 32'hFFFFFFF0, 1'b0},
    {4'hC, 32'h0,        32'h0,        8'h16, 8'h14, 32'h00008001, 1'b0},
    {4'hB, 32'h0,        32'h0,        8'h16, 8'h14, 32'h0,        1'b0},
    {4'h8, 32'h0,        32'h0,        8'h10, 8'h0C, 32'h8899AABB, 1'b0},
    {4'hF, 32'h0,        32'h0,        8'h18, 8'h14, 32'h00C0FFEE, 1'b0},
    {4'h5, 32'hFFFFFFFF, 32'h0,        8'h30, 8'h30, 32'h0,        1'b1},
    {4'h3, 32'h7F000080, 32'h0,        8'h20, 8'h24, 32'h0,        1'b0},
    {4'hA, 32'h0,        32'h0,        8'h20, 8'h1F, 32'h00000080, 1'b0},
    {4'hD, 32'h0,        32'h0,        8'h20, 8'h1C, 32'h7F000000, 1'b0},
    {4'h1, 32'h00000085, 32'h0,        8'h23, 8'h24, 32'h0,        1'b0},
    {4'h9, 32'h0,        32'h0,        8'h23, 8'h22, 32'hFFFFFF85, 1'b0},
    {4'hE, 32'h0,        32'h0,        8'h20, 8'h1C, 32'h0,        1'b0},
    {4'h7, 32'h0,        32'h0,        8'h40, 8'h40, 32'h0,        1'b1}
  };

  task automatic runOp(input logic [3:0] op, input logic [31:0] d, input logic [31:0] pc,
                       input logic [7:0] sp, output int lat, output int acc);
    int acc0;
    @(negedge clk);
    opValid = 1'b1; opCode = op; opData = d; pcIn = pc; spIn = sp;
    acc0 = memAcc;
    @(negedge clk);
    opValid = 1'b0;
    lat = 1;
    while (!done && lat < 10) begin
      @(negedge clk);
      lat++;
    end
    acc = memAcc - acc0;
  endtask

  initial begin
    int lat, acc, expLat, expAcc;
    logic [3:0] op;
    logic isErr;

    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    check("R1 busy/done/err/memEn in reset", {28'h0, busy, done, err, memEn}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle flags after reset", {28'h0, busy, done, err, memEn}, 32'h0);
    check("R1 spOut after reset", {24'h0, spOut}, 32'h0);
    check("R1 popData after reset", popData, 32'h0);

    // Table walk: R2 R3 R4 R6 R8 results, R7 latency, R5/R8 access counts
    for (int v = 0; v < NV; v++) begin
      op = VEC[v][116:113];
      isErr = VEC[v][0];
      runOp(op, VEC[v][112:81], VEC[v][80:49], VEC[v][48:41], lat, acc);
      expLat = isErr ? 1 : (op[3] ? 3 : 2);
      expAcc = isErr ? 0 : (op[3] ? 2 : 1);
      check($sformatf("R2/R4/R6 spOut vec%0d", v), {24'h0, spOut}, {24'h0, VEC[v][40:33]});
      check($sformatf("R4/R6 popData vec%0d", v), popData, VEC[v][32:1]);
      check($sformatf("R8 err vec%0d", v), {31'h0, err}, {31'h0, isErr});
      check($sformatf("R7 latency vec%0d", v), lat, expLat);
      check($sformatf("R5/R8 access count vec%0d", v), acc, expAcc);
      @(negedge clk);
      check($sformatf("R7 done pulse ends vec%0d", v), {30'h0, done, busy}, 32'h0);
    end

    // R5: every popped location reads back zero
    begin
      logic [31:0] orv = '0;
      for (int a = 8'h10; a < 8'h28; a++) orv |= 32'(mem[a]);
      check("R5 popped bytes cleared", orv, 32'h0);
    end

    // R2: narrow pushes leave neighbours untouched, little-endian lanes
    runOp(4'h1, 32'hFFFFFF5A, 32'h0, 8'h41, lat, acc);
    runOp(4'h1, 32'hAAAAAA77, 32'h0, 8'h40, lat, acc);
    runOp(4'h2, 32'h5555BEEF, 32'h0, 8'h42, lat, acc);
    check("R2 byte lane 0", {24'h0, mem[8'h40]}, 32'h77);
    check("R2 neighbour untouched", {24'h0, mem[8'h41]}, 32'h5A);
    check("R2 halfword lanes", {16'h0, mem[8'h43], mem[8'h42]}, 32'hBEEF);
    check("R2 spOut after push16", {24'h0, spOut}, 32'h44);
    runOp(4'h0, 32'h11223344, 32'h0, 8'h50, lat, acc);
    check("R2 word little-endian", {mem[8'h53], mem[8'h52], mem[8'h51], mem[8'h50]}, 32'h11223344);
    // R3: pc push stores pcIn, not opData
    runOp(4'h4, 32'h0BADF00D, 32'hCAFE1234, 8'h58, lat, acc);
    check("R3 pc stored", {mem[8'h5B], mem[8'h5A], mem[8'h59], mem[8'h58]}, 32'hCAFE1234);
    check("R3 spOut", {24'h0, spOut}, 32'h5C);

    // R9: request while busy is ignored
    begin
      int acc0;
      @(negedge clk);
      opValid = 1'b1; opCode = 4'hA; spIn = 8'h50; opData = '0;
      acc0 = memAcc;
      @(negedge clk);
      opValid = 1'b1; opCode = 4'h0; spIn = 8'h60; opData = 32'hFFFFFFFF;
      @(negedge clk);
      opValid = 1'b0;
      @(negedge clk);
      check("R9 done at pop latency", {31'h0, done}, 32'h1);
      check("R9 popData unaffected", popData, 32'h44);
      check("R9 spOut unaffected", {24'h0, spOut}, 32'h4F);
      check("R9 no extra access", memAcc - acc0, 2);
      check("R9 ignored target untouched", {mem[8'h63], mem[8'h62], mem[8'h61], mem[8'h60]}, 32'h0);
      @(negedge clk);
      check("R9 idle after", {31'h0, busy}, 32'h0);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule